// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It uses two inputs together: a few low address bits of the branch, and the resolved directions of the last several branches the machine has seen, whichever branch they were. A shift register keeps those recent directions. Each address-selected entry holds one small saturating counter for every possible history pattern. The history register picks the counter inside the entry. The counter's top bit is the guess.

A fetch stage presents a branch PC on the lookup port and gets the prediction back combinationally, in the same cycle. When the branch resolves, the back end presents its PC and actual direction on the update port. The block then moves the counter chosen by the present history one step toward that direction and shifts the direction into the history. The counter storage holds 2^HIST_LEN × ENTRY_CNT counters of CTR_W bits each. The history length, counter width, entry count, PC width and alignment are all parameters.

Top module: `gp_correlator`

## Requirements
- R1: After reset, and after any later reset, the history register is all zeros and every counter holds 0 (strongly not taken). Every lookup therefore predicts not taken until updates arrive.
- R2: `lk_taken` is the most significant bit of the counter at address {history, lk_pc[ALIGN_BITS+IDX_W-1:ALIGN_BITS]}, with the history in the upper bits. The value is produced combinationally in the same cycle. With the defaults (ALIGN_BITS=2, 16 entries) the index field is lk_pc[5:2], and a value of 1 means taken.
- R3: An update with `upd_taken`=1 raises the selected counter by one. A counter already at 2^CTR_W−1 keeps that value.
- R4: An update with `upd_taken`=0 lowers the selected counter by one. A counter already at 0 keeps that value.
- R5: Every update with `upd_valid` high shifts `upd_taken` into history bit 0. Each older bit moves up one place, and the oldest bit is dropped.
- R6: While `upd_valid` is low, `upd_pc` and `upd_taken` have no effect: neither the history nor any counter changes.
- R7: One index used under different history values reaches separate counters. Different indices under one history value also reach separate counters.
- R8: PC bits below the alignment field and above the index field play no part in selecting an entry. Such addresses alias onto the same counters.
- R9: If a lookup and an update happen in the same cycle, the lookup sees the state from before the update. The update selects its counter with the history from before its own shift, and its effect shows from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A lookup and an update can land in the same cycle, often on the very counter the lookup reads. The stimulus table pairs every lookup with an update to the same branch. In one row the counter crosses from weakly not-taken to weakly taken, so a design that forwards the new value would predict taken one row too early. The expected values assume that the lookup and the update's counter choice both use the history and counters from before that clock edge. The next row then confirms that the crossing has been stored.

// File: rtl/gp_pkg.sv
`timescale 1ns/1ps
package gp_pkg;

   // Direction encoding shared by ports and history bits.
   typedef enum logic {
      DIR_NOT_TAKEN = 1'b0,
      DIR_TAKEN     = 1'b1
   } gp_dir_e;

   // True when v is a positive power of two.
   function automatic bit gp_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/gp_hist.sv
`timescale 1ns/1ps
// Global outcome shift register; newest outcome enters bit 0.
module gp_hist #(
   parameter int HIST_LEN = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic                bit_in,
   output logic [HIST_LEN-1:0] hist_q
);

   logic [HIST_LEN-1:0] hist_d;

   generate
      if (HIST_LEN == 1) begin : g_single
         assign hist_d = bit_in;
      end else begin : g_multi
         assign hist_d = {hist_q[HIST_LEN-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (shift_en) begin
         hist_q <= hist_d;
      end
   end

endmodule

// File: rtl/gp_addr.sv
`timescale 1ns/1ps
// Forms a counter address: history above, word-aligned PC index below.
module gp_addr #(
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2,
   parameter int IDX_W      = 4,
   parameter int HIST_LEN   = 2,
   localparam int AW        = HIST_LEN + IDX_W
) (
   input  logic [PC_W-1:0]     pc,
   input  logic [HIST_LEN-1:0] hist,
   output logic [AW-1:0]       addr
);

   localparam int IDX_LO = ALIGN_BITS;
   localparam int IDX_HI = ALIGN_BITS + IDX_W - 1;

   logic unused_pc_bits;

   assign addr           = {hist, pc[IDX_HI:IDX_LO]};
   assign unused_pc_bits = ^{pc[PC_W-1:IDX_HI+1], pc[IDX_LO-1:0]};

endmodule

// File: rtl/gp_bank.sv
`timescale 1ns/1ps
// Saturating counter storage with one combinational read port and one
// read-modify-write update port.
module gp_bank #(
   parameter int CTR_W = 2,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          rd_addr,
   output logic                   rd_msb,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic                   wr_taken,
   output logic [DEPTH*CTR_W-1:0] bank_flat
);

   logic [CTR_W-1:0] wr_next;

   assign rd_msb = bank_flat[int'(rd_addr)*CTR_W + CTR_W - 1];

   generate
      if (CTR_W == 1) begin : g_bit
         // A one-bit counter simply records the last outcome.
         assign wr_next = wr_taken;
      end else begin : g_sat
         localparam logic [CTR_W-1:0] CMAX = '1;
         logic [CTR_W-1:0] wr_cur;
         assign wr_cur = bank_flat[int'(wr_addr)*CTR_W +: CTR_W];
         always_comb begin
            if (wr_taken) begin
               wr_next = (wr_cur == CMAX) ? wr_cur : wr_cur + 1'b1;
            end else begin
               wr_next = (wr_cur == '0) ? wr_cur : wr_cur - 1'b1;
            end
         end
      end
   endgenerate

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [CTR_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (wr_en && (wr_addr == AW'(g))) begin
            slot_q <= wr_next;
         end
      end
      assign bank_flat[g*CTR_W +: CTR_W] = slot_q;
   end

endmodule

// File: rtl/gp_correlator.sv
`timescale 1ns/1ps
module gp_correlator #(
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2,
   parameter int ENTRY_CNT  = 16,
   parameter int HIST_LEN   = 2,
   parameter int CTR_W      = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int IDX_W = $clog2(ENTRY_CNT);
   localparam int AW    = HIST_LEN + IDX_W;
   localparam int DEPTH = 1 << AW;

   // Elaboration-time parameter checks.
   if (!gp_pkg::gp_is_pow2(ENTRY_CNT) || ENTRY_CNT < 2) begin : g_bad_entries
      $error("ENTRY_CNT must be a power of two, at least 2");
   end
   if (HIST_LEN < 1 || HIST_LEN > 12) begin : g_bad_hist
      $error("HIST_LEN must lie in 1..12");
   end
   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_ctr
      $error("CTR_W must lie in 1..8");
   end
   if (ALIGN_BITS < 1 || PC_W <= ALIGN_BITS + IDX_W) begin : g_bad_pc
      $error("PC_W must exceed ALIGN_BITS + index width, ALIGN_BITS >= 1");
   end

   logic [HIST_LEN-1:0]    hist_q;
   logic [AW-1:0]          lk_addr;
   logic [AW-1:0]          upd_addr;
   logic [DEPTH*CTR_W-1:0] bank_flat;

   gp_hist #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .bit_in   (upd_taken),
      .hist_q   (hist_q)
   );

   gp_addr #(
      .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN)
   ) u_lk_addr (
      .pc   (lk_pc),
      .hist (hist_q),
      .addr (lk_addr)
   );

   gp_addr #(
      .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN)
   ) u_upd_addr (
      .pc   (upd_pc),
      .hist (hist_q),
      .addr (upd_addr)
   );

   gp_bank #(.CTR_W(CTR_W), .DEPTH(DEPTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (lk_addr),
      .rd_msb    (lk_taken),
      .wr_en     (upd_valid),
      .wr_addr   (upd_addr),
      .wr_taken  (upd_taken),
      .bank_flat (bank_flat)
   );

endmodule

// File: rtl/gp_correlator_chk.sv
`timescale 1ns/1ps
module gp_correlator_chk #(
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2,
   parameter int ENTRY_CNT  = 16,
   parameter int HIST_LEN   = 2,
   parameter int CTR_W      = 2,
   localparam int IDX_W     = $clog2(ENTRY_CNT),
   localparam int AW        = HIST_LEN + IDX_W,
   localparam int DEPTH     = 1 << AW
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [PC_W-1:0]        lk_pc,
   input logic                   lk_taken,
   input logic                   upd_valid,
   input logic [PC_W-1:0]        upd_pc,
   input logic                   upd_taken,
   input logic [HIST_LEN-1:0]    hist_q,
   input logic [DEPTH*CTR_W-1:0] bank_flat
);

   localparam int IDX_LO = ALIGN_BITS;
   localparam int IDX_HI = ALIGN_BITS + IDX_W - 1;
   localparam logic [CTR_W-1:0] CMAX = '1;

   logic [AW-1:0]    chk_lk_addr;
   logic [AW-1:0]    chk_upd_addr;
   logic [AW-1:0]    upd_addr_q;
   logic [CTR_W-1:0] upd_cur;
   logic [CTR_W-1:0] upd_post;
   logic             lk_ref;
   logic             unused_chk_bits;

   assign chk_lk_addr  = {hist_q, lk_pc[IDX_HI:IDX_LO]};
   assign chk_upd_addr = {hist_q, upd_pc[IDX_HI:IDX_LO]};
   assign lk_ref       = bank_flat[int'(chk_lk_addr)*CTR_W + CTR_W - 1];
   assign upd_cur      = bank_flat[int'(chk_upd_addr)*CTR_W +: CTR_W];
   assign upd_post     = bank_flat[int'(upd_addr_q)*CTR_W +: CTR_W];
   assign unused_chk_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0],
                              upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

   always_ff @(posedge clk) begin
      upd_addr_q <= chk_upd_addr;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (hist_q == '0) && (bank_flat == '0));

   // R2
   lookup_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken == lk_ref);

   // R3
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && upd_cur != CMAX)
      |=> upd_post == CTR_W'($past(upd_cur) + 1'b1));

   // R3
   sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && upd_cur == CMAX) |=> upd_post == CMAX);

   // R4
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && upd_cur != '0)
      |=> upd_post == CTR_W'($past(upd_cur) - 1'b1));

   // R4
   sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && upd_cur == '0) |=> upd_post == '0);

   // R5
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> hist_q[0] == $past(upd_taken));

   generate
      if (HIST_LEN > 1) begin : g_body
         // R5
         shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_valid |=> hist_q[HIST_LEN-1:1] == $past(hist_q[HIST_LEN-2:0]));
      end
   endgenerate

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(hist_q) && $stable(bank_flat));

endmodule

bind gp_correlator gp_correlator_chk #(
   .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .ENTRY_CNT(ENTRY_CNT),
   .HIST_LEN(HIST_LEN), .CTR_W(CTR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_pc     (lk_pc),
   .lk_taken  (lk_taken),
   .upd_valid (upd_valid),
   .upd_pc    (upd_pc),
   .upd_taken (upd_taken),
   .hist_q    (hist_q),
   .bank_flat (bank_flat)
);

// File: tb/tb_gp_correlator.sv
`timescale 1ns/1ps
module tb_gp_correlator;

   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b1;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_taken;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   gp_correlator #(
      .PC_W(PC_W), .ALIGN_BITS(2), .ENTRY_CNT(16), .HIST_LEN(2), .CTR_W(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   typedef struct packed {
      logic        uv;
      logic [31:0] upc;
      logic        ut;
      logic [31:0] lpc;
      logic        exp;
      logic [3:0]  req;
   } vec_t;

   // Each row: lookup checked before the edge, update applied at the edge.
   // Index field is pc[5:2]; 0x10 -> 4, 0x20 -> 8, 0x24 -> 9.
   localparam int NVEC = 17;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b0, 4'd9}, // R9 h00 c0 -> 1, h=01
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b0, 4'd5}, // R5 h01 c0 -> 1, h=11
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b0, 4'd7}, // R7 h11 c0 -> 1
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b0, 4'd9}, // R9 h11 c1 -> 2, pre value seen
      '{1'b0, 32'h10, 1'b1, 32'h10,   1'b1, 4'd3}, // R3 c2 predicts taken; R6 idle
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b1, 4'd6}, // R6 idle left c2; -> 3
      '{1'b1, 32'h10, 1'b1, 32'h10,   1'b1, 4'd3}, // R3 c3 saturates
      '{1'b1, 32'h10, 1'b0, 32'h10,   1'b1, 4'd3}, // R3 still 3; -> 2, h=10
      '{1'b0, 32'h10, 1'b0, 32'h10,   1'b0, 4'd7}, // R7 h10 separate counter 0
      '{1'b1, 32'h10, 1'b0, 32'h10,   1'b0, 4'd4}, // R4 h10 c0 stays 0, h=00
      '{1'b1, 32'h10, 1'b0, 32'h53,   1'b0, 4'd8}, // R8 alias; h00 c1 -> 0
      '{1'b1, 32'h10, 1'b0, 32'h10,   1'b0, 4'd4}, // R4 c0 saturates low
      '{1'b1, 32'h20, 1'b1, 32'h10,   1'b0, 4'd2}, // R2 h00 A=0; B -> 1, h=01
      '{1'b1, 32'h20, 1'b1, 32'h10,   1'b0, 4'd2}, // R2 h01 A=1; h=11
      '{1'b0, 32'h20, 1'b0, 32'h1010, 1'b1, 4'd8}, // R8 high bits ignored, h11 A=2
      '{1'b0, 32'h20, 1'b0, 32'h20,   1'b0, 4'd7}, // R7 h11 B separate, 0
      '{1'b0, 32'h20, 1'b0, 32'h24,   1'b0, 4'd7}  // R7 neighbour index 0
   };

   task automatic check(input logic got, input logic exp, input int req,
                        input string what);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                       input logic [31:0] lpc);
      @(negedge clk);
      upd_valid = uv;
      upd_pc    = upc;
      upd_taken = ut;
      lk_pc     = lpc;
      #1;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      // R1 during reset: all counters read as strongly not taken
      step(1'b0, 32'h0, 1'b0, 32'h10);
      check(lk_taken, 1'b0, 1, "reset lookup 0x10");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 32'h0, 1'b0, 32'h3c);
      check(lk_taken, 1'b0, 1, "post-reset lookup 0x3c");
      step(1'b0, 32'h0, 1'b0, 32'hfffffffc);
      check(lk_taken, 1'b0, 1, "post-reset lookup top");

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].lpc);
         check(lk_taken, VEC[i].exp, int'(VEC[i].req),
               $sformatf("vector %0d", i));
      end

      // R2 state before a second reset: history 11, counter at index 4 holds 2
      step(1'b0, 32'h0, 1'b0, 32'h10);
      check(lk_taken, 1'b1, 2, "pre-reset lookup");

      // R1 reset mid-run clears counters and history
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 32'h20, 1'b1, 32'h10);
      step(1'b1, 32'h20, 1'b1, 32'h10);
      step(1'b0, 32'h0, 1'b0, 32'h10);
      check(lk_taken, 1'b0, 1, "counter cleared by second reset");

      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         report();
         $finish;
      end
   end

endmodule